// File: doc/BRIEF.md
# Zero-Byte Squeezer

This block removes zero bytes from fixed-size chunks of a byte stream. In compress mode it forwards every nonzero byte in arrival order and drops every zero byte. At the end of each chunk it sends a presence bitmap with one bit per input position. It also reports how many bytes were kept, so the caller can place the next compressed chunk straight after this one. The bitmap travels on the same output port as the data, and a kind flag tells the two apart.

In expand mode the block reverses the operation. It first takes a full chunk's bitmap, then the stored nonzero bytes. It rebuilds the chunk by placing a stored byte at each marked position and a zero everywhere else. All ports use valid/ready flow control. With the output side ready, the block accepts one byte per cycle.

Top module: `zero_byte_squeezer`

## Requirements
- R1: In compress mode, a zero input byte never appears on the output. Each nonzero input byte appears with `out_kind`=0, in input order, one cycle after it is accepted.
- R2: After a chunk's last data byte, ceil(n/8) bitmap bytes follow with `out_kind`=1, where n is the chunk length. Bit k of bitmap byte j is 1 exactly when input byte 8j+k was nonzero. `out_last` is 1 only on the final bitmap byte.
- R3: A compress chunk ends on the byte accepted with `in_last`=1, or on the CHUNK-th byte, whichever comes first. Bitmap bits beyond the chunk length are 0.
- R4: When a chunk ends, `kept_cnt` takes the number of nonzero bytes in that chunk. It holds that value for the whole time the bitmap bytes are presented.
- R5: In expand mode the block accepts CHUNK/8 bitmap bytes, with bit k of byte j standing for position 8j+k. It then emits CHUNK bytes. A 1 bit consumes and emits the next input byte. A 0 bit emits 0x00 and consumes nothing. `out_last` marks the final byte, and `in_last` is ignored.
- R6: `mode` (0 = compress, 1 = expand) takes effect only between chunks. It must be held for at least one idle cycle before the first byte of a chunk.
- R7: While `out_valid` is high and `out_ready` is low, the output fields stay unchanged. In compress mode, with `out_ready` held high, `in_ready` stays high for every data byte of a chunk.
- R8: After reset, `out_valid`=0, `kept_cnt`=0, and the block is in compress mode with `in_ready`=1.
- R9: An all-zero chunk produces no data bytes, only all-zero bitmap bytes, with `kept_cnt`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | 0 compress, 1 expand |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Final byte of a compress chunk |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts output |
| out_data | output | 8 | Output byte |
| out_kind | output | 1 | 0 data byte, 1 bitmap byte |
| out_last | output | 1 | Final output byte of a chunk |
| kept_cnt | output | $clog2(CHUNK+1) | Nonzero byte count of the latest compressed chunk |

## Verification
A wrong position counter shows first as a misplaced chunk boundary: `out_last` or the bitmap-byte count is wrong by the end of that same chunk. A corrupted presence bit shows in the bitmap bytes of that chunk, and in expand mode it also shifts every later byte of the chunk at once. A stale kept count is caught on the first bitmap byte after the chunk's data. A lost or duplicated byte breaks the in-order match against the expected stream on the next output transfer.

// File: rtl/zero_byte_squeezer.sv
module zero_byte_squeezer #(
  parameter int CHUNK = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         mode,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [7:0]                   in_data,
  input  logic                         in_last,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [7:0]                   out_data,
  output logic                         out_kind,
  output logic                         out_last,
  output logic [$clog2(CHUNK+1)-1:0]   kept_cnt
);
  localparam int NB = CHUNK / 8;
  localparam int PW = $clog2(CHUNK);
  localparam int BW = PW - 3;
  localparam int KW = $clog2(CHUNK + 1);
  localparam logic [PW-1:0] LASTP = PW'(CHUNK - 1);
  localparam logic [BW-1:0] LASTB = BW'(NB - 1);

  typedef enum logic [1:0] {S_IN = 2'd0, S_BM = 2'd1, S_XBM = 2'd2, S_XOUT = 2'd3} st_t;

  st_t st, st_home;
  logic [CHUNK-1:0] bm;
  logic [PW-1:0] pos;
  logic [BW-1:0] bidx, bm_last;
  logic [KW-1:0] kept, kept_nx;
  logic can_load, acc, nz, xbit, x_step, c_end;
  logic ld, ld_kind, ld_last;
  logic [7:0] ld_data, bm_byte;

  assign st_home  = mode ? S_XBM : S_IN;
  assign can_load = !out_valid || out_ready;
  assign nz       = in_data != 8'h00;
  assign xbit     = bm[pos];
  assign bm_byte  = bm[{bidx, 3'b000} +: 8];
  assign in_ready = (st == S_IN && can_load) || st == S_XBM || (st == S_XOUT && can_load && xbit);
  assign acc      = in_valid && in_ready;
  assign x_step   = st == S_XOUT && can_load && (!xbit || in_valid);
  assign c_end    = in_last || pos == LASTP;
  assign kept_nx  = kept + {{(KW-1){1'b0}}, nz};

  always_comb begin
    ld = 1'b0;
    ld_data = in_data;
    ld_kind = 1'b0;
    ld_last = 1'b0;
    case (st)
      S_IN: ld = acc && nz;
      S_BM: begin
        ld = can_load;
        ld_data = bm_byte;
        ld_kind = 1'b1;
        ld_last = bidx == bm_last;
      end
      S_XOUT: begin
        ld = x_step;
        ld_data = xbit ? in_data : 8'h00;
        ld_last = pos == LASTP;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= 8'h00;
      out_kind  <= 1'b0;
      out_last  <= 1'b0;
    end else if (ld) begin
      out_valid <= 1'b1;
      out_data  <= ld_data;
      out_kind  <= ld_kind;
      out_last  <= ld_last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IN;
      bm       <= '0;
      pos      <= '0;
      bidx     <= '0;
      bm_last  <= '0;
      kept     <= '0;
      kept_cnt <= '0;
    end else begin
      case (st)
        S_IN: begin
          if (acc) begin
            bm[pos] <= nz;
            if (c_end) begin
              st       <= S_BM;
              kept_cnt <= kept_nx;
              kept     <= '0;
              bm_last  <= pos[PW-1:3];
              bidx     <= '0;
              pos      <= '0;
            end else begin
              kept <= kept_nx;
              pos  <= pos + 1'b1;
            end
          end else if (pos == '0) begin
            st <= st_home;
          end
        end
        S_BM: begin
          if (can_load) begin
            if (bidx == bm_last) begin
              st   <= st_home;
              bm   <= '0;
              bidx <= '0;
            end else begin
              bidx <= bidx + 1'b1;
            end
          end
        end
        S_XBM: begin
          if (acc) begin
            bm[{bidx, 3'b000} +: 8] <= in_data;
            if (bidx == LASTB) begin
              st   <= S_XOUT;
              bidx <= '0;
              pos  <= '0;
            end else begin
              bidx <= bidx + 1'b1;
            end
          end else if (bidx == '0) begin
            st <= st_home;
          end
        end
        default: begin
          if (x_step) begin
            if (pos == LASTP) begin
              st  <= st_home;
              pos <= '0;
              bm  <= '0;
            end else begin
              pos <= pos + 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/zero_byte_squeezer_chk.sv
module zero_byte_squeezer_chk #(
  parameter int KW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [7:0]    in_data,
  input logic          out_valid,
  input logic          out_ready,
  input logic [7:0]    out_data,
  input logic          out_kind,
  input logic          out_last,
  input logic [KW-1:0] kept_cnt,
  input logic [1:0]    st,
  input logic          xbit
);
  p_zero_dropped_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && in_valid && in_ready && in_data == 8'h00) |=> !out_valid);

  p_kept_forward_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && in_valid && in_ready && in_data != 8'h00)
      |=> (out_valid && !out_kind && out_data == $past(in_data)));

  p_count_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind && !out_last) |=> $stable(kept_cnt));

  p_skip_no_consume_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd3 && !xbit) |-> !in_ready);

  p_bitmap_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2) |-> in_ready);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready)
      |=> (out_valid && $stable(out_data) && $stable(out_kind) && $stable(out_last)));
endmodule

bind zero_byte_squeezer zero_byte_squeezer_chk #(.KW($clog2(CHUNK+1))) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_kind(out_kind),
  .out_last(out_last), .kept_cnt(kept_cnt), .st(st), .xbit(xbit)
);

// File: tb/tb_zero_byte_squeezer.sv
module tb_zero_byte_squeezer;
  localparam int CLK_PERIOD = 10;
  localparam int CHUNK = 64;
  localparam int NB = CHUNK / 8;
  localparam int KW = $clog2(CHUNK + 1);

  logic clk = 1'b0, rst_n = 1'b0, mode = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
  logic [7:0] in_data = 8'h00;
  logic in_ready, out_valid, out_kind, out_last;
  logic [7:0] out_data;
  logic [KW-1:0] kept_cnt;

  zero_byte_squeezer #(.CHUNK(CHUNK)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_kind(out_kind), .out_last(out_last), .kept_cnt(kept_cnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0, n_fail = 0, stalls = 0, cyc = 0;
  bit stall_en = 1'b0, done = 1'b0, had_stall = 1'b0;
  logic [10:0] held;
  logic [9:0] expq[$];
  string tagq[$];
  int cntq[$];
  logic [7:0] mem [0:2*CHUNK-1];

  always @(posedge clk) cyc <= cyc + 1;

  initial forever begin
    @(negedge clk);
    out_ready = !stall_en || ((cyc % 5) < 3);
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic check(input string tag, input int got, input int expv);
    n_tests++;
    if (got != expv) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, expv);
    end
  endtask

  initial forever begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      if (had_stall) check("R7 hold", int'({out_valid, out_kind, out_last, out_data}), int'(held));
      had_stall = out_valid && !out_ready;
      held = {1'b1, out_kind, out_last, out_data};
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check("R1 unexpected output", int'({out_kind, out_last, out_data}), -1);
        end else begin
          logic [9:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          check(t, int'({out_kind, out_last, out_data}), int'(e));
          if (out_kind) check("R4 kept count", int'(kept_cnt), cntq.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog: got hang expected completion");
    finish_run();
  end

  task automatic send(input logic [7:0] d, input bit l);
    in_valid = 1'b1;
    in_data = d;
    in_last = l;
    forever begin
      #1;
      if (in_ready) begin
        @(negedge clk);
        break;
      end
      stalls++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last = 1'b0;
  endtask

  task automatic exp_comp(input int s, input int n, input string btag);
    int kept = 0;
    int nb = (n + 7) / 8;
    for (int i = 0; i < n; i++) begin
      if (mem[s+i] != 8'h00) begin
        expq.push_back({2'b00, mem[s+i]});
        tagq.push_back("R1 data byte");
        kept++;
      end
    end
    for (int j = 0; j < nb; j++) begin
      logic [7:0] b = 8'h00;
      for (int k = 0; k < 8; k++)
        if (8*j + k < n && mem[s+8*j+k] != 8'h00) b[k] = 1'b1;
      expq.push_back({1'b1, j == nb - 1, b});
      tagq.push_back(btag);
      cntq.push_back(kept);
    end
  endtask

  task automatic exp_expand();
    for (int i = 0; i < CHUNK; i++) begin
      expq.push_back({1'b0, i == CHUNK - 1, mem[i]});
      tagq.push_back("R5 expanded byte");
    end
  endtask

  task automatic drive_expand();
    for (int j = 0; j < NB; j++) begin
      logic [7:0] b = 8'h00;
      for (int k = 0; k < 8; k++) b[k] = mem[8*j+k] != 8'h00;
      send(b, 1'b0);
    end
    for (int i = 0; i < CHUNK; i++)
      if (mem[i] != 8'h00) send(mem[i], 1'b1);
  endtask

  task automatic wait_drain(input string tag);
    int w = 0;
    while (expq.size() != 0 && w < 3000) begin
      @(negedge clk);
      w++;
    end
    repeat (3) @(negedge clk);
    check(tag, expq.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R8 out_valid at reset", int'(out_valid), 0);
    check("R8 kept_cnt at reset", int'(kept_cnt), 0);
    check("R8 in_ready at reset", int'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R8 idle after reset", int'({in_ready, out_valid}), 2);
    @(negedge clk);

    for (int i = 0; i < CHUNK; i++) mem[i] = (i % 3 == 0) ? 8'h00 : 8'(i + 1);
    exp_comp(0, CHUNK, "R2 bitmap full chunk");
    stalls = 0;
    for (int i = 0; i < CHUNK; i++) send(mem[i], i == CHUNK - 1);
    check("R7 no input stalls", stalls, 0);
    wait_drain("R2 drain full chunk");

    for (int i = 0; i < 13; i++) mem[i] = (i % 2 == 1) ? 8'(8'h5A + i) : 8'h00;
    exp_comp(0, 13, "R3 short chunk bitmap");
    for (int i = 0; i < 13; i++) send(mem[i], i == 12);
    wait_drain("R3 drain short chunk");

    for (int i = 0; i < CHUNK; i++) mem[i] = 8'h00;
    exp_comp(0, CHUNK, "R9 all-zero bitmap");
    for (int i = 0; i < CHUNK; i++) send(mem[i], i == CHUNK - 1);
    wait_drain("R9 drain all-zero");

    stall_en = 1'b1;
    for (int i = 0; i < CHUNK; i++) mem[i] = (i % 5 == 0) ? 8'h00 : (8'(i * 37) ^ 8'h55) | 8'h01;
    exp_comp(0, CHUNK, "R7 bitmap under backpressure");
    for (int i = 0; i < CHUNK; i++) send(mem[i], i == CHUNK - 1);
    wait_drain("R7 drain backpressure");
    stall_en = 1'b0;

    for (int i = 0; i < CHUNK + 5; i++) mem[i] = (i % 4 == 1) ? 8'h00 : 8'(i + 3);
    exp_comp(0, CHUNK, "R3 auto end at CHUNK");
    exp_comp(CHUNK, 5, "R3 tail chunk");
    for (int i = 0; i < CHUNK + 5; i++) send(mem[i], i == CHUNK + 4);
    wait_drain("R3 drain split chunks");

    mode = 1'b1;
    repeat (3) @(negedge clk);
    stall_en = 1'b1;
    for (int i = 0; i < CHUNK; i++) mem[i] = (i % 4 < 2) ? 8'h00 : 8'(200 + i);
    exp_expand();
    drive_expand();
    wait_drain("R5 drain expand backpressure");
    stall_en = 1'b0;

    for (int i = 0; i < CHUNK; i++) mem[i] = (i == 0 || i == CHUNK - 1) ? 8'h00 : 8'(i);
    exp_expand();
    drive_expand();
    wait_drain("R6 drain expand second chunk");

    mode = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 8; i++) mem[i] = 8'(i + 9);
    exp_comp(0, 8, "R6 compress after expand");
    for (int i = 0; i < 8; i++) send(mem[i], i == 7);
    wait_drain("R6 drain back to compress");

    finish_run();
  end
endmodule